// File: doc/BRIEF.md
# Universal Serial Shift Unit

This block is a general-purpose serial shifter with an 8-bit shift register and a 4-bit transfer counter. Three pins carry the serial traffic: serial data in, serial data out and a serial clock. The block can run as the clock-driving end (master) or the clock-receiving end (slave) of a three-wire link that behaves like SPI mode 0 or mode 1. It has no slave-select input; software does that job. Data moves most significant bit first. Data out always shows the bit that was launched last, and data in is shifted into the LSB on the sampling edge.

Each shift step can come from one of three sources. The first is the serial clock line, on which both edges count. The second is a compare-match pulse from a timer. The third is a software strobe. A master produces its serial clock by writing a toggle bit. The counter wraps from 15 to 0, and that wrap raises a sticky overflow flag that can drive the interrupt. Software can preload the counter to set a shorter transfer. A two-wire option detects a start condition, which is data falling while the clock line is high. With clock hold enabled, the block asserts a hold output after a start or an overflow. The hold pulls the clock low and freezes the shifter until software clears the flag.

Top module: `ssu_top`

## Requirements
- R1: After synchronous reset, the data register, counter, both flags, control, `sck_out`, `sdo`, `sck_hold` and `irq` are all zero.
- R2: Register reads by `rd_addr`: 0 gives shift data; 1 gives status {start flag bit 7, overflow flag bit 6, zeros, counter bits 3:0}; 2 gives control; 3 gives {0000, counter}. Control layout: bit 7 overflow irq enable, bit 6 start irq enable, bit 5 clock hold enable, bit 4 two-wire, bit 3 master, bit 2 phase (0 = mode 0, 1 = mode 1), bits 1:0 source (0 off, 1 clock line, 2 timer, 3 software strobe).
- R3: With the clock-line source, every rising and every falling edge of the line advances the counter by one. The line is `sck_out` when master and the synchronised `sck_in` when slave. Sixteen edges wrap the counter to 0 and set the overflow flag.
- R4: In mode 0, a rising line edge shifts the shift register left with `sdi` into the LSB, and a falling edge drives the register MSB onto `sdo`. Writing the data register also puts its bit 7 on `sdo`.
- R5: In mode 1, a rising edge drives the MSB onto `sdo` and a falling edge shifts `sdi` into the LSB.
- R6: With the timer source, each `tmr_match` pulse shifts one bit, advances the counter and puts the new MSB on `sdo`. With any other source, the pulse leaves the counter unchanged.
- R7: With the software source, writing address 3 with bit 6 set performs one shift step and one count.
- R8: Writing address 3 with bit 5 set inverts `sck_out`.
- R9: Writing address 3 with bit 4 set loads the counter from bits 3:0. A load in the same cycle as a count step wins.
- R10: Writing address 1 with bit 6 set clears the overflow flag, and writing bit 7 set clears the start flag. A wrap in the same cycle as a clear leaves the overflow flag set.
- R11: `irq` is high when a flag is set and its enable bit is set. It is low when both enables are clear.
- R12: In two-wire mode, a falling synchronised `sdi` while the line is high sets the start flag.
- R13: With hold enabled, `sck_hold` is high while the overflow flag is set, or while the start flag is set in two-wire mode. While it is high, no count or shift happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sck_in | input | 1 | Serial clock line as seen at the pin |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_hold | output | 1 | Request to hold the clock line low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tmr_match | input | 1 | Timer compare-match pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked deliberately. In the first, a timer pulse that wraps the counter from 15 lands in the same cycle as a software write that clears the overflow flag. The flag must read back set and the counter must read back 0. In the second, a counter load coincides with a timer count step, and the counter must read back the loaded value and not that value plus one. The bench issues both events on the same clock edge by asserting `tmr_match` during the register write, and judges the outcome through a status read afterwards.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;

    // command bits at A_CMD
    localparam int CMD_LOAD = 4;
    localparam int CMD_TOG  = 5;
    localparam int CMD_STEP = 6;
    // status bits at A_STAT
    localparam int ST_START = 7;
    localparam int ST_OVF   = 6;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_LINE  = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_SOFT  = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     ovf_ie;
        logic     start_ie;
        logic     hold_en;
        logic     twowire;
        logic     master;
        logic     cpha;
        clk_src_e src;
    } ctrl_t;

    // picks the sampling edge (or launch edge) for the selected phase
    function automatic logic pick_edge(input logic cpha, input logic rise,
                                       input logic fall, input logic sample);
        return (cpha ^ sample) ? rise : fall;
    endfunction
endpackage

// File: rtl/ssu_line_front.sv
module ssu_line_front #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_pin,
    input  logic sdi_pin,
    input  logic master,
    input  logic sck_drv,
    output logic line_lvl,
    output logic line_rise,
    output logic line_fall,
    output logic sdi_s,
    output logic sdi_fall
);
    logic [SYNC-1:0] sck_sy, sdi_sy;
    logic            line_q, sdi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy <= '0;
            sdi_sy <= '0;
            line_q <= 1'b0;
            sdi_q  <= 1'b0;
        end else begin
            sck_sy <= {sck_sy[SYNC-2:0], sck_pin};
            sdi_sy <= {sdi_sy[SYNC-2:0], sdi_pin};
            line_q <= line_lvl;
            sdi_q  <= sdi_s;
        end
    end

    assign line_lvl  = master ? sck_drv : sck_sy[SYNC-1];
    assign sdi_s     = sdi_sy[SYNC-1];
    assign line_rise = line_lvl & ~line_q;
    assign line_fall = ~line_lvl & line_q;
    assign sdi_fall  = ~sdi_s & sdi_q;
endmodule

// File: rtl/ssu_shift_core.sv
module ssu_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sdi,
    input  logic         launch,
    input  logic         strobe,
    output logic [W-1:0] sh,
    output logic         sdo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (load) begin
            sh  <= load_val;
            sdo <= load_val[W-1];
        end else begin
            if (shift) sh <= {sh[W-2:0], sdi};
            if (strobe)      sdo <= sh[W-2];
            else if (launch) sdo <= sh[W-1];
        end
    end
endmodule

// File: rtl/ssu_xfer_cnt.sv
module ssu_xfer_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         clr_ovf,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    assign wrap = step && !load && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (load)      cnt <= load_val;
            else if (step) cnt <= cnt + 1'b1;
            if (wrap)         ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/ssu_top.sv
module ssu_top
    import ssu_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_hold,
    input  logic              sdi,
    output logic              sdo,
    input  logic              tmr_match,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic              start_q;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q, wrap;
    logic              line_lvl, line_rise, line_fall, sdi_s, sdi_fall;
    logic              hold, pin_act, strobe_ev, sample_ev, launch_ev, count_ev;
    logic              data_wr, cmd_wr, cnt_load, tog_wr, ovf_clr, start_clr, start_set;

    assign data_wr   = wr_en && wr_addr == A_DATA;
    assign cmd_wr    = wr_en && wr_addr == A_CMD;
    assign cnt_load  = cmd_wr && wr_data[CMD_LOAD];
    assign tog_wr    = cmd_wr && wr_data[CMD_TOG];
    assign ovf_clr   = wr_en && wr_addr == A_STAT && wr_data[ST_OVF];
    assign start_clr = wr_en && wr_addr == A_STAT && wr_data[ST_START];

    ssu_line_front #(.SYNC(SYNC)) u_front (
        .clk(clk), .rst(rst), .sck_pin(sck_in), .sdi_pin(sdi),
        .master(ctrl_q.master), .sck_drv(sck_out),
        .line_lvl(line_lvl), .line_rise(line_rise), .line_fall(line_fall),
        .sdi_s(sdi_s), .sdi_fall(sdi_fall)
    );

    assign hold      = ctrl_q.hold_en && (ovf_q || (ctrl_q.twowire && start_q));
    assign pin_act   = !hold && ctrl_q.src == SRC_LINE;
    assign strobe_ev = !hold && ((ctrl_q.src == SRC_TIMER && tmr_match) ||
                                 (ctrl_q.src == SRC_SOFT && cmd_wr && wr_data[CMD_STEP]));
    assign sample_ev = pin_act && pick_edge(ctrl_q.cpha, line_rise, line_fall, 1'b1);
    assign launch_ev = pin_act && pick_edge(ctrl_q.cpha, line_rise, line_fall, 1'b0);
    assign count_ev  = (pin_act && (line_rise || line_fall)) || strobe_ev;
    assign start_set = ctrl_q.twowire && sdi_fall && line_lvl;

    ssu_shift_core #(.W(DATA_W)) u_core (
        .clk(clk), .rst(rst), .load(data_wr), .load_val(wr_data),
        .shift(sample_ev || strobe_ev), .sdi(sdi_s),
        .launch(launch_ev), .strobe(strobe_ev), .sh(sh), .sdo(sdo)
    );

    ssu_xfer_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(wr_data[CNT_W-1:0]),
        .step(count_ev), .clr_ovf(ovf_clr), .cnt(cnt_q), .ovf(ovf_q), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= 1'b0;
            sck_out <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data);
            if (start_set)      start_q <= 1'b1;
            else if (start_clr) start_q <= 1'b0;
            if (tog_wr) sck_out <= ~sck_out;
        end
    end

    assign sck_hold = hold;
    assign irq      = (ctrl_q.ovf_ie && ovf_q) || (ctrl_q.start_ie && start_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DATA:  rd_data = sh;
            A_STAT:  begin
                rd_data[ST_START]  = start_q;
                rd_data[ST_OVF]    = ovf_q;
                rd_data[CNT_W-1:0] = cnt_q;
            end
            A_CTRL:  rd_data = ctrl_q;
            default: rd_data[CNT_W-1:0] = cnt_q;
        endcase
    end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cnt,
    input logic       ovf,
    input logic       wrap,
    input logic       ovf_clr,
    input logic       cnt_load,
    input logic [7:0] wr_data,
    input logic       hold,
    input logic       tog_wr,
    input logic       sck_out,
    input logic [7:0] ctrl,
    input logic       irq
);
    p_wrap_sets_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf);

    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (wrap && ovf_clr) |=> (ovf && cnt == 4'd0));

    p_clear_works_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !wrap) |=> !ovf);

    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> cnt == $past(wr_data[3:0]));

    p_hold_freezes_r13: assert property (@(posedge clk) disable iff (rst)
        (hold && !cnt_load) |=> $stable(cnt));

    p_toggle_flips_r8: assert property (@(posedge clk) disable iff (rst)
        tog_wr |=> sck_out != $past(sck_out));

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[7] && !ctrl[6]) |-> !irq);
endmodule

bind ssu_top ssu_checker u_chk (
    .clk(clk), .rst(rst), .cnt(cnt_q), .ovf(ovf_q), .wrap(wrap),
    .ovf_clr(ovf_clr), .cnt_load(cnt_load), .wr_data(wr_data),
    .hold(hold), .tog_wr(tog_wr), .sck_out(sck_out),
    .ctrl(ctrl_q), .irq(irq)
);

// File: tb/tb_ssu_top.sv
module tb_ssu_top;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sck_in = 1'b0, sck_out, sck_hold, sdi = 1'b0, sdo, tmr_match = 1'b0, irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;
    item_t q[$];

    ssu_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sck_in(sck_in), .sck_out(sck_out),
        .sck_hold(sck_hold), .sdi(sdi), .sdo(sdo), .tmr_match(tmr_match), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pins view: {irq, sck_hold, sdo, sck_out}
    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = (it.sel == PINS) ? {4'b0, irq, sck_hold, sdo, sck_out} : rd_data;
                vectors++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                             it.tag, act & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic expect_v(input int sel, input logic [7:0] exp,
                            input logic [7:0] mask, input string tag);
        item_t it;
        @(negedge clk);
        if (sel != PINS) rd_addr = sel[1:0];
        it.sel = sel; it.exp = exp; it.mask = mask; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic toggle();
        wr(2'd3, 8'h20);
        settle();
    endtask

    task automatic tpulse();
        @(negedge clk);
        tmr_match = 1'b1;
        @(negedge clk);
        tmr_match = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] pat, ld;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_v(0, 8'h00, 8'hFF, "R1 data");
        expect_v(1, 8'h00, 8'hFF, "R1 status");
        expect_v(2, 8'h00, 8'hFF, "R1 ctrl");
        expect_v(PINS, 8'h00, 8'h0F, "R1 pins");

        // R4 mode 0 master exchange, R8 toggle
        wr(2'd2, 8'h09);
        ld = 8'hA5; pat = 8'h3C;
        wr(2'd0, ld);
        for (int i = 0; i < 8; i++) begin
            sdi = pat[7-i];
            repeat (2) @(negedge clk);
            expect_v(PINS, {5'b0, ld[7-i], 1'b0}, 8'h02, "R4 sdo before rise");
            toggle();
            if (i == 0) expect_v(PINS, 8'h01, 8'h01, "R8 sck_out high after toggle");
            toggle();
        end
        expect_v(0, pat, 8'hFF, "R4 data after 8 clocks");
        expect_v(1, 8'h40, 8'hFF, "R3 wrap after 16 edges");
        expect_v(2, 8'h09, 8'hFF, "R2 ctrl readback");
        wr(2'd1, 8'h40);
        expect_v(1, 8'h00, 8'hFF, "R10 ovf cleared");

        // R5 mode 1 master exchange
        wr(2'd2, 8'h0D);
        ld = 8'h96; pat = 8'hC3;
        wr(2'd0, ld);
        for (int i = 0; i < 8; i++) begin
            toggle();
            expect_v(PINS, {5'b0, ld[7-i], 1'b0}, 8'h02, "R5 sdo after rise");
            sdi = pat[7-i];
            repeat (2) @(negedge clk);
            toggle();
        end
        expect_v(0, pat, 8'hFF, "R5 data after 8 clocks");
        expect_v(1, 8'h40, 8'hFF, "R5 ovf after transfer");
        wr(2'd1, 8'h40);

        // R3 slave edge counting
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h10);
        sck_in = 1'b1; settle();
        sck_in = 1'b0; settle();
        sck_in = 1'b1; settle();
        expect_v(3, 8'h03, 8'hFF, "R3 three edges counted");

        // R6 timer source with preload R9
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h18);
        pat = 8'hE1;
        for (int i = 0; i < 8; i++) begin
            sdi = pat[7-i];
            repeat (3) @(negedge clk);
            tpulse();
        end
        expect_v(0, pat, 8'hFF, "R6 timer data");
        expect_v(1, 8'h40, 8'hFF, "R9 preload 8 wraps after 8");
        expect_v(PINS, 8'h02, 8'h02, "R6 sdo new MSB");

        // R7 software source, timer ignored
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h40);
        wr(2'd3, 8'h1D);
        tpulse();
        expect_v(3, 8'h0D, 8'hFF, "R6 timer ignored under soft source");
        sdi = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) wr(2'd3, 8'h40);
        expect_v(0, 8'h0F, 8'hFF, "R7 soft strobes shift");
        expect_v(1, 8'h40, 8'hFF, "R7 soft strobes wrap");

        // R10 wrap and clear in same cycle
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h1F);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h40; tmr_match = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_match = 1'b0;
        expect_v(1, 8'h40, 8'hFF, "R10 set beats clear");
        wr(2'd1, 8'h40);
        expect_v(1, 8'h00, 8'hFF, "R10 later clear");

        // R9 load and count in same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h15; tmr_match = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_match = 1'b0;
        expect_v(3, 8'h05, 8'hFF, "R9 load beats count");

        // R11 interrupt
        wr(2'd2, 8'h82);
        wr(2'd3, 8'h1F);
        tpulse();
        expect_v(PINS, 8'h08, 8'h0C, "R11 irq on overflow");
        wr(2'd1, 8'h40);
        expect_v(PINS, 8'h00, 8'h0C, "R11 irq drops after clear");

        // R13 hold after overflow
        wr(2'd2, 8'h22);
        wr(2'd3, 8'h1F);
        tpulse();
        expect_v(PINS, 8'h04, 8'h0C, "R13 hold after overflow");
        tpulse();
        expect_v(3, 8'h00, 8'hFF, "R13 no count while held");
        wr(2'd1, 8'h40);
        tpulse();
        expect_v(3, 8'h01, 8'hFF, "R13 counts after release");
        expect_v(PINS, 8'h00, 8'h04, "R13 hold released");

        // R12 two-wire start detection
        sdi = 1'b1;
        wr(2'd3, 8'h10);
        settle();
        wr(2'd2, 8'h71);
        settle();
        sdi = 1'b0;
        settle();
        expect_v(1, 8'h80, 8'hFF, "R12 start flag");
        expect_v(PINS, 8'h0C, 8'h0C, "R12 irq and hold on start");
        expect_v(2, 8'h71, 8'hFF, "R2 ctrl readback two-wire");
        wr(2'd1, 8'h80);
        expect_v(1, 8'h00, 8'hFF, "R10 start cleared");
        expect_v(PINS, 8'h00, 8'h0C, "R12 irq and hold drop");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule